// File: doc/BRIEF.md
# Four-Bank FFT Butterfly Memory Scheduler

This block generates the memory traffic for an in-place radix-2 FFT whose butterfly unit takes one operand pair per clock and returns its results one cycle later. The working storage is split into four single-port banks. A logical address goes to the bank formed from its top bit and its parity, the XOR of all its bits. The word address inside that bank is the logical address with both the top bit and the lowest bit removed. Two butterfly partners differ in exactly one bit, so they always have opposite parity. Because they sit in different banks, both operands can be fetched in the same cycle.

Within each stage the scheduler picks an order in which neighbouring butterflies touch disjoint bank pairs. The results of one butterfly can then be written back while the next one reads. Before the final stage, the order alternates the top address bit. In the final stage it alternates the parity. One bank collision is left, at the step into the final stage. It is caught by comparing the read banks with the banks under writeback, and the read is held for one cycle. A start pulse launches a transform of 128, 256, 512 or 1024 points of 16-bit words. The block drives per-bank read and write enables and word addresses. It raises a done pulse once the last result has been written.

Top module: `fft_bank_sched`

## Requirements
- R1: size_sel picks N = 128 << size_sel (L = 7 + size_sel address bits). A run has L stages in ascending order. In stage s, each pair (a, a + 2^s) with bit s of a clear is read exactly once, and every pair of stage s is read before any pair of stage s+1.
- R2: Logical address a is stored in bank 2*a[L-1] + (XOR of all bits of a). Its word index on rd_addr/wr_addr is a[L-2:1]. Bank b owns bits [8b+7 : 8b] of the address buses.
- R3: In every cycle, rd_en has either no bit set or exactly two bits set. The two enabled banks hold the two operands of one butterfly.
- R4: Writeback follows one cycle after the read. wr_en in cycle t+1 equals rd_en in cycle t, with the same word addresses on each enabled bank.
- R5: A bank is never read and written in the same cycle. A read that would collide with the writeback is held for one cycle, and stall_cnt goes up by one. stall_cnt clears on an accepted start.
- R6: Within a stage, consecutive butterflies use disjoint bank pairs. A full transform therefore stalls exactly once and keeps busy high for L*N/2 + 1 cycles.
- R7: busy falls in the cycle of the final writeback. done is high for exactly one cycle, the cycle after that final writeback.
- R8: A start pulse while busy is high is ignored. The running transform keeps its size and its length.
- R9: After reset the block is idle: busy, done and all read and write enables are low, and stall_cnt is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a transform (accepted only while idle) |
| size_sel | input | 2 | Transform size: 128 << size_sel points |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle pulse after the final writeback |
| stall_cnt | output | 16 | Stall cycles in the current or last transform |
| rd_en | output | 4 | Per-bank read enable |
| rd_addr | output | 32 | Per-bank read word index, 8 bits per bank |
| rd_lo_bank | output | 2 | Bank holding the lower-address operand of the current read |
| wr_en | output | 4 | Per-bank write enable |
| wr_addr | output | 32 | Per-bank write word index, 8 bits per bank |
| wr_lo_bank | output | 2 | Bank receiving the lower-address result |

## Verification
The embedded assertions guard the behaviour that is local to each cycle. Reads and writes never share a bank. Reads come in pairs. Writes mirror the previous cycle's reads. Every idle read slot during a run is explained by a pending write, and that slot bumps the stall counter. A start during a run leaves the latched size alone, and done never lasts two cycles. Only the bench's sweeps can show the global properties. These are that every butterfly of every stage is visited exactly once and in stage order, that the bank and word mapping decodes back to the right partner addresses, that one stall per transform is the whole cost, and that the run length and done timing are right for all four sizes.

// File: rtl/fft_bank_sched.sv
module fft_bank_sched #(
  parameter int LOG_MIN = 7,
  parameter int SEL_W   = 2,
  parameter int CNT_W   = 16,
  localparam int LOG_MAX = LOG_MIN + (1 << SEL_W) - 1,
  localparam int AW      = LOG_MAX,
  localparam int IW      = LOG_MAX - 2,
  localparam int SW      = $clog2(LOG_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEL_W-1:0] size_sel,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] stall_cnt,
  output logic [3:0]       rd_en,
  output logic [4*IW-1:0]  rd_addr,
  output logic [1:0]       rd_lo_bank,
  output logic [3:0]       wr_en,
  output logic [4*IW-1:0]  wr_addr,
  output logic [1:0]       wr_lo_bank
);

  logic [SW-1:0]   lg, stg;
  logic [AW-2:0]   k, j, kmax;
  logic [AW-1:0]   lo, hi;
  logic [1:0]      blo, bhi, wb_blo, wb_bhi;
  logic [IW-1:0]   ilo, ihi, wb_ilo, wb_ihi, imask;
  logic            wb_v, wb_last, conflict, issue, last_k, last_stg;

  assign last_stg = (stg == lg - SW'(1));
  assign kmax     = ((AW-1)'(1) << (lg - SW'(1))) - (AW-1)'(1);
  assign last_k   = (k == kmax);
  assign imask    = (IW'(1) << (lg - SW'(2))) - IW'(1);

  always_comb begin
    if (last_stg) j = {k[AW-2:1], k[0] ^ (^(k >> 1))};
    else          j = (k >> 1) | ((AW-1)'(k[0]) << (lg - SW'(2)));
    lo  = ((AW'(j) >> stg) << (stg + SW'(1))) | (AW'(j) & ((AW'(1) << stg) - AW'(1)));
    hi  = lo | (AW'(1) << stg);
    blo = {lo[lg - SW'(1)], ^lo};
    bhi = {hi[lg - SW'(1)], ^hi};
    ilo = IW'(lo >> 1) & imask;
    ihi = IW'(hi >> 1) & imask;
  end

  assign conflict = busy && wb_v &&
                    (blo == wb_blo || blo == wb_bhi || bhi == wb_blo || bhi == wb_bhi);
  assign issue    = busy && !conflict;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lg <= SW'(LOG_MIN); stg <= '0; k <= '0; busy <= 1'b0;
      wb_v <= 1'b0; wb_last <= 1'b0; done <= 1'b0; stall_cnt <= '0;
      wb_blo <= '0; wb_bhi <= '0; wb_ilo <= '0; wb_ihi <= '0;
    end else begin
      wb_v    <= issue;
      wb_last <= issue && last_k && last_stg;
      done    <= wb_v && wb_last;
      if (issue) begin
        wb_blo <= blo; wb_bhi <= bhi; wb_ilo <= ilo; wb_ihi <= ihi;
      end
      if (!busy && start) begin
        lg <= SW'(LOG_MIN) + SW'(size_sel);
        stg <= '0; k <= '0; busy <= 1'b1; stall_cnt <= '0;
      end else if (conflict) begin
        stall_cnt <= stall_cnt + CNT_W'(1);
      end else if (issue) begin
        if (last_k) begin
          k <= '0;
          if (last_stg) busy <= 1'b0;
          else          stg <= stg + SW'(1);
        end else begin
          k <= k + (AW-1)'(1);
        end
      end
    end
  end

  assign rd_lo_bank = blo;
  assign wr_lo_bank = wb_blo;

  for (genvar b = 0; b < 4; b++) begin : g_bank
    assign rd_en[b] = issue && (blo == 2'(b) || bhi == 2'(b));
    assign wr_en[b] = wb_v && (wb_blo == 2'(b) || wb_bhi == 2'(b));
    assign rd_addr[b*IW +: IW] = !rd_en[b] ? '0 : (blo == 2'(b)) ? ilo : ihi;
    assign wr_addr[b*IW +: IW] = !wr_en[b] ? '0 : (wb_blo == 2'(b)) ? wb_ilo : wb_ihi;
  end

  // R5
  rd_wr_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en & wr_en) == 4'b0);

  // R3
  rd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rd_en) == 0 || $countones(rd_en) == 2);

  // R4
  wb_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> wr_en == $past(rd_en));

  // R5
  stall_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en == 4'b0) |-> wr_en != 4'b0);

  // R5
  stall_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en == 4'b0 && !start) |=> stall_cnt == $past(stall_cnt) + CNT_W'(1));

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(lg));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/sim_fft_bank_sched.sv
module sim_fft_bank_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  size_sel = 2'd0;
  logic        busy, done;
  logic [15:0] stall_cnt;
  logic [3:0]  rd_en, wr_en;
  logic [31:0] rd_addr, wr_addr;
  logic [1:0]  rd_lo_bank, wr_lo_bank;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  fft_bank_sched u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel),
    .busy(busy), .done(done), .stall_cnt(stall_cnt),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_lo_bank(rd_lo_bank),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_lo_bank(wr_lo_bank)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int decode(int b, int i, int L);
    int a;
    a = ((b >> 1) << (L - 1)) | (i << 1);
    return a | ((b & 1) ^ ($countones(a) & 1));
  endfunction

  task automatic run(input int sel, input bit poke);
    int L, N, half, issued, stalls, busy_cyc, a0, a1, lo, hi, stage, cnt;
    logic [3:0]  prev_rd;
    logic [31:0] prev_addr;
    bit seen [0:1023];
    L = 7 + sel; N = 1 << L; half = N / 2;
    issued = 0; stalls = 0; busy_cyc = 0; prev_rd = '0; prev_addr = '0;
    foreach (seen[x]) seen[x] = 1'b0;
    @(negedge clk); start = 1'b1; size_sel = 2'(sel);
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", busy, 1);
    chk(stall_cnt == 16'd0, "R5 stall_cnt cleared", stall_cnt, 0);
    while (busy && busy_cyc < 20000) begin
      busy_cyc++;
      chk(wr_en == prev_rd, "R4 write enables", wr_en, prev_rd);
      for (int b = 0; b < 4; b++)
        if (prev_rd[b])
          chk(wr_addr[b*8 +: 8] == prev_addr[b*8 +: 8], "R4 write address",
              wr_addr[b*8 +: 8], prev_addr[b*8 +: 8]);
      chk((rd_en & wr_en) == 4'b0, "R5 bank read and write", rd_en & wr_en, 0);
      if (rd_en == 4'b0) begin
        stalls++;
      end else begin
        cnt = $countones(rd_en);
        chk(cnt == 2, "R3 pair read", cnt, 2);
        a0 = -1; a1 = -1;
        for (int b = 0; b < 4; b++)
          if (rd_en[b]) begin
            chk(rd_addr[b*8 +: 8] < (N >> 2), "R2 index range", rd_addr[b*8 +: 8], N >> 2);
            if (a0 < 0) a0 = decode(b, rd_addr[b*8 +: 8], L);
            else        a1 = decode(b, rd_addr[b*8 +: 8], L);
          end
        lo = (a0 < a1) ? a0 : a1; hi = (a0 < a1) ? a1 : a0;
        stage = issued / half;
        chk(hi - lo == (1 << stage), "R2 partner distance", hi - lo, 1 << stage);
        chk((lo & (1 << stage)) == 0 && !seen[lo & 1023], "R1 unique butterfly", lo, stage);
        chk(decode(rd_lo_bank, rd_addr[rd_lo_bank*8 +: 8], L) == lo, "R2 lo bank", rd_lo_bank, lo);
        seen[lo & 1023] = 1'b1;
        issued++;
        if (issued % half == 0) foreach (seen[x]) seen[x] = 1'b0;
      end
      prev_rd = rd_en; prev_addr = rd_addr;
      if (poke && busy_cyc == 100) begin start = 1'b1; size_sel = 2'd3; end
      else begin start = 1'b0; size_sel = 2'(sel); end
      @(negedge clk);
    end
    chk(wr_en == prev_rd && prev_rd != 4'b0, "R7 final write as busy falls", wr_en, prev_rd);
    chk(done == 1'b0, "R7 done not early", done, 0);
    chk(issued == L * half, "R1 butterfly count", issued, L * half);
    chk(busy_cyc == L * half + 1, "R6 busy length", busy_cyc, L * half + 1);
    chk(stalls == 1, "R6 single stall", stalls, 1);
    chk(stall_cnt == 16'(stalls), "R5 stall_cnt", stall_cnt, stalls);
    if (poke) chk(issued == L * half, "R8 start during run ignored", issued, L * half);
    @(negedge clk);
    chk(done == 1'b1, "R7 done pulse", done, 1);
    chk(wr_en == 4'b0 && rd_en == 4'b0, "R7 idle after run", {rd_en, wr_en}, 0);
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R9 reset idle", {busy, done}, 0);
    chk(rd_en == 4'b0 && wr_en == 4'b0, "R9 reset enables", {rd_en, wr_en}, 0);
    chk(stall_cnt == 16'd0, "R9 reset stall_cnt", stall_cnt, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 0; s < 4; s++) run(s, 1'b0);
    run(0, 1'b1);
    run(2, 1'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    tests++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule